// File: doc/BRIEF.md
# Programmable TFT Display Timing Generator

This block produces the raster timing for a TFT panel with a parallel or 8-bit serial RGB interface. It runs a pixel counter across each line and a line counter down each frame, and from them derives horizontal sync, vertical sync, a data-enable window and a once-per-pixel request toward a pixel FIFO. Software sets it up through a small write port. The programmable values are the sync widths, the active-area start and end positions packed as 16-bit pairs, and the line and frame totals.

Timing values written by software go into shadow registers. They are copied into the working set only when a frame starts, so a frame in flight never changes shape. In serial mode each pixel takes three clocks, one per colour channel. Two shutdowns are offered. A graceful stop finishes the current frame and then sets a done flag. A hard stop idles the outputs at once.

The controller has three states: IDLE, RUN and DRAIN. Its transitions are:
- START (IDLE to RUN): enabled and no stop requested.
- SOFT_STOP (RUN to DRAIN): stop requested.
- DRAIN_DONE (DRAIN to IDLE): at the frame end.
- HARD_STOP (RUN or DRAIN to IDLE): enable cleared.

Top module: `tft_timing_gen`

## Requirements
- R1: After reset all outputs are low, pix_x and pix_y are 0 and stop_done is 0.
- R2: While running, pix_x counts 0 to htot-1 and wraps. pix_y advances on each wrap and itself wraps after vtot-1. The totals sit in address 5: htot in bits 31:16 and vtot in bits 15:0.
- R3: hsync is high while pix_x is below the horizontal sync width (address 1, bits 15:0). vsync is high while pix_y is below the vertical sync width (address 2, bits 15:0).
- R4: de is high only when pix_x is in [hstart, hend) and pix_y is in [vstart, vend). The horizontal window is at address 3 and the vertical window at address 4, each with start in bits 31:16 and end in bits 15:0.
- R5: pix_req pulses once per pixel, on the pixel's first clock, and only while de is high.
- R6: When control bit 2 (serial) is set, each pixel lasts three clocks. With it clear, each pixel lasts one clock.
- R7: Writes to addresses 1 to 5 and to the serial bit take effect only at the start of the next frame.
- R8: In IDLE, a control word (address 0) with bit 0 (enable) set and bit 1 (stop) clear starts a frame at pixel 0, line 0 on the clock after the write.
- R9: Clearing the enable bit idles all outputs from the clock after the write edge.
- R10: Setting the stop bit lets the current frame finish. The block then idles, raises stop_done, and stays idle while the stop bit is set.
- R11: stop_done clears when a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data-enable window |
| pix_req | output | 1 | One pulse per active pixel to the pixel FIFO |
| pix_x | output | 16 | Current pixel within the line |
| pix_y | output | 16 | Current line within the frame |
| stop_done | output | 1 | Graceful stop completed |

## Verification
The bench uses the default 16-bit counter width. It programs small rasters: a 10 by 6 total that is then rewritten to 12 by 7 while a frame is in flight. With rasters this small, several full frames, the frame-boundary reload, both stops and a complete serial frame all fit in a few hundred cycles. Every pixel-clock cycle of these frames is compared against a model of the raster, including the idle cycles after a graceful stop.

// File: rtl/tft_pkg.sv
package tft_pkg;
    localparam int TW = 16;
    localparam int DW = 2 * TW;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_HSW   = 3'd1;
    localparam logic [AW-1:0] A_VSW   = 3'd2;
    localparam logic [AW-1:0] A_HWIN  = 3'd3;
    localparam logic [AW-1:0] A_VWIN  = 3'd4;
    localparam logic [AW-1:0] A_TOTAL = 3'd5;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_t;

    typedef struct packed {
        logic [TW-1:0] hsw;
        logic [TW-1:0] vsw;
        logic [TW-1:0] hs;
        logic [TW-1:0] he;
        logic [TW-1:0] vs;
        logic [TW-1:0] ve;
        logic [TW-1:0] htot;
        logic [TW-1:0] vtot;
        logic          serial;
    } timing_t;
endpackage

// File: rtl/tft_regs.sv
module tft_regs
    import tft_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          load_act,
    output logic          ctl_en,
    output logic          ctl_stop,
    output timing_t       act
);
    timing_t shadow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow   <= '0;
            ctl_en   <= 1'b0;
            ctl_stop <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ctl_en        <= wr_data[0];
                    ctl_stop      <= wr_data[1];
                    shadow.serial <= wr_data[2];
                end
                A_HSW:   shadow.hsw <= wr_data[TW-1:0];
                A_VSW:   shadow.vsw <= wr_data[TW-1:0];
                A_HWIN:  begin shadow.hs   <= wr_data[DW-1:TW]; shadow.he   <= wr_data[TW-1:0]; end
                A_VWIN:  begin shadow.vs   <= wr_data[DW-1:TW]; shadow.ve   <= wr_data[TW-1:0]; end
                A_TOTAL: begin shadow.htot <= wr_data[DW-1:TW]; shadow.vtot <= wr_data[TW-1:0]; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        act <= '0;
        else if (load_act) act <= shadow;
    end
endmodule

// File: rtl/tft_axis.sv
module tft_axis
    import tft_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [TW-1:0] total,
    input  logic [TW-1:0] sync_w,
    input  logic [TW-1:0] win_s,
    input  logic [TW-1:0] win_e,
    output logic [TW-1:0] pos,
    output logic          at_end,
    output logic          in_sync,
    output logic          in_win
);
    assign at_end  = (pos == total - 1'b1);
    assign in_sync = (pos < sync_w);
    assign in_win  = (pos >= win_s) && (pos < win_e);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) pos <= '0;
        else if (step)     pos <= at_end ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
    import tft_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_req,
    output logic [15:0]   pix_x,
    output logic [15:0]   pix_y,
    output logic          stop_done
);
    state_t        state, state_nx;
    timing_t       act;
    logic          ctl_en, ctl_stop;
    logic [1:0]    phase;
    logic          running, tick, h_step, v_step, frame_end, start, load_act;
    logic [TW-1:0] h_pos, v_pos;
    logic          h_end, v_end, h_sync, v_sync, h_win, v_win;

    assign running   = (state != ST_IDLE);
    assign tick      = !act.serial || (phase == 2'd2);
    assign h_step    = running && tick;
    assign v_step    = h_step && h_end;
    assign frame_end = v_step && v_end;
    assign start     = (state == ST_IDLE) && ctl_en && !ctl_stop;
    assign load_act  = start || ((state == ST_RUN) && frame_end);

    tft_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_act(load_act), .ctl_en(ctl_en),
        .ctl_stop(ctl_stop), .act(act)
    );

    tft_axis u_hax (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(h_step),
        .total(act.htot), .sync_w(act.hsw), .win_s(act.hs), .win_e(act.he),
        .pos(h_pos), .at_end(h_end), .in_sync(h_sync), .in_win(h_win)
    );

    tft_axis u_vax (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(v_step),
        .total(act.vtot), .sync_w(act.vsw), .win_s(act.vs), .win_e(act.ve),
        .pos(v_pos), .at_end(v_end), .in_sync(v_sync), .in_win(v_win)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !running) phase <= 2'd0;
        else if (act.serial)    phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
        else                    phase <= 2'd0;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_RUN;
            ST_RUN: begin
                if (!ctl_en)       state_nx = ST_IDLE;
                else if (ctl_stop) state_nx = ST_DRAIN;
            end
            ST_DRAIN: if (!ctl_en || frame_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     stop_done <= 1'b0;
        else if (start) stop_done <= 1'b0;
        else if ((state == ST_DRAIN) && ctl_en && frame_end) stop_done <= 1'b1;
    end

    always_comb begin
        hsync   = running && h_sync;
        vsync   = running && v_sync;
        de      = running && h_win && v_win;
        pix_req = de && (phase == 2'd0);
        pix_x   = running ? h_pos : '0;
        pix_y   = running ? v_pos : '0;
    end
endmodule

// File: rtl/tft_timing_chk.sv
module tft_timing_chk
    import tft_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input state_t        state,
    input logic          ctl_en,
    input logic          stop_done,
    input logic          pix_req,
    input logic          de,
    input logic [15:0]   pix_x,
    input logic [15:0]   pix_y,
    input logic [TW-1:0] act_htot,
    input logic          act_serial
);
    AST_REQ_IN_DE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> de); // R5

    AST_X_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (pix_x < act_htot)); // R2

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && ($past(state) != ST_IDLE) && !act_serial && (pix_x != 16'd0))
        |-> (pix_x == $past(pix_x) + 16'd1)); // R6

    AST_HARD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !ctl_en) |=> (state == ST_IDLE)); // R9

    AST_DONE_FROM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_done) |-> ($past(state) == ST_DRAIN)); // R10

    AST_TIMING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && ($past(state) != ST_IDLE) && !((pix_x == 16'd0) && (pix_y == 16'd0)))
        |-> $stable(act_htot)); // R7
endmodule

bind tft_timing_gen tft_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .ctl_en(ctl_en),
    .stop_done(stop_done), .pix_req(pix_req), .de(de), .pix_x(pix_x),
    .pix_y(pix_y), .act_htot(act.htot), .act_serial(act.serial)
);

// File: tb/tb_tft_timing_gen.sv
module tb_tft_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int HSW = 2, VSW = 1, HS = 3, HE = 8, VS = 2, VE = 5;
    localparam int HT_A = 10, VT_A = 6, HT_B = 12, VT_B = 7;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, pix_req, stop_done;
    logic [15:0] pix_x, pix_y;

    int n_chk = 0, n_bad = 0;
    bit mon_on = 1'b0;
    logic [35:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tft_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_req(pix_req), .pix_x(pix_x), .pix_y(pix_y), .stop_done(stop_done)
    );

    task automatic check(input bit ok, input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [35:0] ev(int c, bit ser, int ht, int vt);
        int p, ph, q, x, y;
        logic hs, vs, d, rq;
        p  = ser ? c / 3 : c;
        ph = ser ? c % 3 : 0;
        q  = p % (ht * vt);
        x  = q % ht;
        y  = q / ht;
        hs = (x < HSW);
        vs = (y < VSW);
        d  = (x >= HS) && (x < HE) && (y >= VS) && (y < VE);
        rq = d && (ph == 0);
        return {hs, vs, d, rq, 16'(x), 16'(y)};
    endfunction

    task automatic push(input logic [35:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // monitor: pops one expected item per cycle and compares at the ports
    always @(negedge clk) begin
        if (mon_on) begin
            logic [35:0] got, e;
            string t;
            got = {hsync, vsync, de, pix_req, pix_x, pix_y};
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got == e, t, got, e);
            if (exp_q.size() == 0) mon_on = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({hsync, vsync, de, pix_req, pix_x, pix_y, stop_done} == '0, "R1 reset",
              {hsync, vsync, de, pix_req, pix_x, pix_y}, '0);

        wr(3'd1, HSW);
        wr(3'd2, VSW);
        wr(3'd3, (HS << 16) | HE);
        wr(3'd4, (VS << 16) | VE);
        wr(3'd5, (HT_A << 16) | VT_A);

        // scenario A: parallel frame, then totals rewritten mid-frame (R7)
        push(ev(0, 1'b0, HT_A, VT_A), "R8 start at origin");
        for (int c = 1; c < HT_A * VT_A; c++) push(ev(c, 1'b0, HT_A, VT_A), "R2 R3 R4 R5");
        for (int c = 0; c < HT_B * VT_B; c++) push(ev(c, 1'b0, HT_B, VT_B), "R7 new totals");
        wr(3'd0, 32'd1);
        mon_on <= 1'b1;
        repeat (20) @(negedge clk);
        wr(3'd5, (HT_B << 16) | VT_B);
        while (mon_on) @(negedge clk);

        // R9: quick disable
        wr(3'd0, 32'd0);
        @(negedge clk);
        check({hsync, vsync, de, pix_req, pix_x, pix_y} == '0, "R9 hard stop",
              {hsync, vsync, de, pix_req, pix_x, pix_y}, '0);
        check(stop_done == 1'b0, "R9 no done flag", {35'd0, stop_done}, '0);

        // R10: graceful stop finishes frame, then idles and stays idle
        for (int c = 0; c < HT_B * VT_B; c++) push(ev(c, 1'b0, HT_B, VT_B), "R10 drain frame");
        for (int c = 0; c < 4; c++) push('0, "R10 idle after drain");
        wr(3'd0, 32'd1);
        mon_on <= 1'b1;
        repeat (10) @(negedge clk);
        wr(3'd0, 32'd3);
        while (mon_on) @(negedge clk);
        check(stop_done == 1'b1, "R10 done flag", {35'd0, stop_done}, 36'd1);

        // R6: serial mode, three clocks per pixel; R11 flag cleared on start
        for (int c = 0; c < 3 * HT_B * VT_B; c++) push(ev(c, 1'b1, HT_B, VT_B), "R6 serial");
        wr(3'd0, 32'd5);
        mon_on <= 1'b1;
        @(negedge clk);
        check(stop_done == 1'b0, "R11 done cleared", {35'd0, stop_done}, '0);
        while (mon_on) @(negedge clk);

        summary();
        $finish;
    end
endmodule